// File: doc/BRIEF.md
# Keyed-lock pad delay register bank

This block is the register file of a pad delay controller. It sits on a simple 32-bit bus that takes one request per cycle and answers reads one cycle later. The bank holds three calibration registers, whose values come from input ports and not from the bus. It also holds a global lock register, which opens only when a 16-bit key is written to it. Above these sits a region of per-pad registers, three words per pad. The first word of each pad carries that pad's coarse and fine delay codes.

A write to any per-pad word must pass three checks in the same cycle. The bank must be globally open. The stored word's own lock bit must be clear. The written word must carry the required 6-bit signature. A write that fails any check leaves the word untouched and raises a sticky error flag. A separate selector picks one pad, and the block drives that pad's stored coarse and fine codes on its outputs so the pad logic can use them.

Top module: `iodly_regbank`

## Requirements
- R1: After reset, bank_locked is 1, wr_err is 0, bus_rvalid is 0, every per-pad word reads zero, and the lock register at byte offset 0x2C reads 0x0000AAAB.
- R2: A write to offset 0x2C whose low 16 bits are 0xAAAA opens the bank, and 0xAAAB closes it. The lock register then reads 0x0000AAAA or 0x0000AAAB. Any other value changes nothing and raises no error.
- R3: A read request (bus_sel=1, bus_wr=0) is answered on the next cycle with bus_rvalid=1 and the word on bus_rdata. bus_rvalid is 0 in every cycle that does not follow a read request.
- R4: Offset 0x14 reads {16'h0, reference period}. Offset 0x18 reads {coarse delay count, coarse reference count}. Offset 0x1C reads {fine delay count, fine reference count}. These values are captured from the calibration ports every cycle, and bus writes to these offsets are ignored without error.
- R5: A write to a per-pad word is stored only if three things hold: the bank is open, bit 10 of the stored word is 0, and bits 17:12 of the written word equal 0x29.
- R6: A per-pad write that fails R5 leaves the stored word unchanged and sets wr_err. wr_err stays 1 until reset.
- R7: Once a per-pad word has been stored with bit 10 set, every later write to that word is rejected, even while the bank is open.
- R8: A read of an accepted per-pad word returns all 32 written bits, including the signature, the lock bit and the unused bits.
- R9: pad_coarse carries bits 9:5 and pad_fine carries bits 4:0 of the word at byte offset 0x30 + 12*pad_sel. An accepted write to that word shows on these outputs in the cycle after the write. If pad_sel is not below the pad count, both outputs are 0.
- R10: Offsets above 0xD1C, and offsets 0x00-0x10 and 0x20-0x28, read as zero. Writes to them have no effect and raise no error.
- R11: Per-pad words run from 0x30 to 0xD1C with a stride of 4. Word k after 0x30 belongs to pad k/3, so 0xD14-0xD1C are the three words of pad 275.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Request valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe, one cycle after request |
| cal_ref_period | input | 16 | Reference clock period |
| cal_crs_ref | input | 16 | Coarse reference count |
| cal_crs_dly | input | 16 | Coarse delay count |
| cal_fin_ref | input | 16 | Fine reference count |
| cal_fin_dly | input | 16 | Fine delay count |
| pad_sel | input | PAD_W | Pad whose delay codes are presented |
| pad_coarse | output | 5 | Coarse code of the selected pad |
| pad_fine | output | 5 | Fine code of the selected pad |
| bank_locked | output | 1 | Global lock state |
| wr_err | output | 1 | Sticky rejected-write flag |

## Verification
Two functions can meet in a single cycle. The first is a bus write that commits a new delay word. The second is the pad view, which is showing that same pad through pad_sel. The bench selects the pad first and then writes its configuration word. It expects the new codes on pad_coarse and pad_fine at the first sample after the write edge. It also expects a read issued in the very next cycle to return the new word. The same overlap is provoked with writes that are rejected by the global lock, by the stored lock bit and by a bad signature. In each case the view and the readback must keep the old word, and wr_err must rise in that same cycle.

// File: rtl/iodly_pkg.sv
package iodly_pkg;

  localparam int DATA_W = 32;

  localparam logic [15:0] KEY_OPEN = 16'hAAAA;
  localparam logic [15:0] KEY_SHUT = 16'hAAAB;

  localparam logic [5:0] SIG_PATTERN = 6'h29;
  localparam int SIG_LSB  = 12;
  localparam int SIG_MSB  = 17;
  localparam int LOCK_BIT = 10;
  localparam int CRS_LSB  = 5;
  localparam int CRS_MSB  = 9;
  localparam int FIN_LSB  = 0;
  localparam int FIN_MSB  = 4;

  localparam int WORD_REFCLK = 5;
  localparam int WORD_CCAL   = 6;
  localparam int WORD_FCAL   = 7;
  localparam int WORD_GLOCK  = 11;
  localparam int WORD_PAD0   = 12;

  typedef enum logic [2:0] {
    RC_NONE,
    RC_GLOCK,
    RC_REFCLK,
    RC_CCAL,
    RC_FCAL,
    RC_PAD
  } reg_class_e;

  function automatic logic sig_matches(input logic [DATA_W-1:0] w);
    return w[SIG_MSB:SIG_LSB] == SIG_PATTERN;
  endfunction

  function automatic logic word_frozen(input logic [DATA_W-1:0] w);
    return w[LOCK_BIT];
  endfunction

  function automatic logic [4:0] coarse_of(input logic [DATA_W-1:0] w);
    return w[CRS_MSB:CRS_LSB];
  endfunction

  function automatic logic [4:0] fine_of(input logic [DATA_W-1:0] w);
    return w[FIN_MSB:FIN_LSB];
  endfunction

  function automatic int first_word_of(input int pad, input int regs_per_pad);
    return pad * regs_per_pad;
  endfunction

endpackage

// File: rtl/iodly_addr_dec.sv
module iodly_addr_dec
  import iodly_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int NUM_PADS     = 276,
  parameter int REGS_PER_PAD = 3,
  parameter int IDX_W        = 10
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_class_e        cls,
  output logic [IDX_W-1:0]  pad_word,
  output logic              oob
);

  localparam int NUM_WORDS = NUM_PADS * REGS_PER_PAD;
  localparam int LAST_WORD = WORD_PAD0 + NUM_WORDS - 1;

  logic [31:0] word;
  logic [31:0] rel;

  assign word = 32'(addr[ADDR_W-1:2]);
  assign rel  = word - 32'(WORD_PAD0);
  assign oob  = word > 32'(LAST_WORD);

  always_comb begin
    cls      = RC_NONE;
    pad_word = '0;
    if (!oob) begin
      if (word >= 32'(WORD_PAD0)) begin
        cls      = RC_PAD;
        pad_word = rel[IDX_W-1:0];
      end else begin
        case (word)
          32'(WORD_GLOCK):  cls = RC_GLOCK;
          32'(WORD_REFCLK): cls = RC_REFCLK;
          32'(WORD_CCAL):   cls = RC_CCAL;
          32'(WORD_FCAL):   cls = RC_FCAL;
          default:          cls = RC_NONE;
        endcase
      end
    end
  end

endmodule

// File: rtl/iodly_gate.sv
module iodly_gate
  import iodly_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lock,
  input  logic              wr_pad,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] stored_word,
  output logic              locked,
  output logic              wr_accept,
  output logic              wr_reject,
  output logic              err_sticky
);

  logic locked_q;
  logic err_q;
  logic open_hit;
  logic shut_hit;

  assign open_hit = wr_lock && (wdata[15:0] == KEY_OPEN);
  assign shut_hit = wr_lock && (wdata[15:0] == KEY_SHUT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b1;
    end else if (open_hit) begin
      locked_q <= 1'b0;
    end else if (shut_hit) begin
      locked_q <= 1'b1;
    end
  end

  assign wr_accept = wr_pad && !locked_q && !word_frozen(stored_word)
                     && sig_matches(wdata);
  assign wr_reject = wr_pad && !wr_accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (wr_reject) begin
      err_q <= 1'b1;
    end
  end

  assign locked     = locked_q;
  assign err_sticky = err_q;

endmodule

// File: rtl/iodly_pad_store.sv
module iodly_pad_store
  import iodly_pkg::*;
#(
  parameter int NUM_PADS     = 276,
  parameter int REGS_PER_PAD = 3,
  parameter int IDX_W        = 10,
  parameter int PAD_W        = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rword,
  input  logic [PAD_W-1:0]  view_pad,
  output logic [4:0]        view_coarse,
  output logic [4:0]        view_fine
);

  localparam int NUM_WORDS = NUM_PADS * REGS_PER_PAD;

  logic [DATA_W-1:0] row_q [NUM_WORDS];
  logic [31:0]       vfirst;
  logic              view_ok;
  logic [DATA_W-1:0] vword;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WORDS; i++) row_q[i] <= '0;
    end else if (we) begin
      row_q[widx] <= wdata;
    end
  end

  assign rword = (32'(ridx) < 32'(NUM_WORDS)) ? row_q[ridx] : '0;

  assign vfirst  = 32'(first_word_of(int'(view_pad), REGS_PER_PAD));
  assign view_ok = 32'(view_pad) < 32'(NUM_PADS);
  assign vword   = view_ok ? row_q[vfirst[IDX_W-1:0]] : '0;

  assign view_coarse = coarse_of(vword);
  assign view_fine   = fine_of(vword);

endmodule

// File: rtl/iodly_regbank.sv
module iodly_regbank
  import iodly_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int NUM_PADS     = 276,
  parameter int REGS_PER_PAD = 3,
  parameter int PAD_W        = $clog2(NUM_PADS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic [15:0]       cal_ref_period,
  input  logic [15:0]       cal_crs_ref,
  input  logic [15:0]       cal_crs_dly,
  input  logic [15:0]       cal_fin_ref,
  input  logic [15:0]       cal_fin_dly,
  input  logic [PAD_W-1:0]  pad_sel,
  output logic [4:0]        pad_coarse,
  output logic [4:0]        pad_fine,
  output logic              bank_locked,
  output logic              wr_err
);

  localparam int NUM_WORDS = NUM_PADS * REGS_PER_PAD;
  localparam int IDX_W     = $clog2(NUM_WORDS);

  reg_class_e        cls;
  logic [IDX_W-1:0]  pad_word;
  logic              addr_oob;
  logic              rd_req;
  logic              wr_req;
  logic              wr_lock;
  logic              wr_pad;
  logic              wr_accept;
  logic              wr_reject;
  logic [DATA_W-1:0] pad_rword;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;
  logic [15:0]       refclk_q;
  logic [31:0]       ccal_q;
  logic [31:0]       fcal_q;

  assign rd_req  = bus_sel && !bus_wr;
  assign wr_req  = bus_sel && bus_wr;
  assign wr_lock = wr_req && (cls == RC_GLOCK);
  assign wr_pad  = wr_req && (cls == RC_PAD);

  iodly_addr_dec #(
    .ADDR_W      (ADDR_W),
    .NUM_PADS    (NUM_PADS),
    .REGS_PER_PAD(REGS_PER_PAD),
    .IDX_W       (IDX_W)
  ) u_dec (
    .addr    (bus_addr),
    .cls     (cls),
    .pad_word(pad_word),
    .oob     (addr_oob)
  );

  iodly_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_lock    (wr_lock),
    .wr_pad     (wr_pad),
    .wdata      (bus_wdata),
    .stored_word(pad_rword),
    .locked     (bank_locked),
    .wr_accept  (wr_accept),
    .wr_reject  (wr_reject),
    .err_sticky (wr_err)
  );

  iodly_pad_store #(
    .NUM_PADS    (NUM_PADS),
    .REGS_PER_PAD(REGS_PER_PAD),
    .IDX_W       (IDX_W),
    .PAD_W       (PAD_W)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (wr_accept),
    .widx       (pad_word),
    .wdata      (bus_wdata),
    .ridx       (pad_word),
    .rword      (pad_rword),
    .view_pad   (pad_sel),
    .view_coarse(pad_coarse),
    .view_fine  (pad_fine)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refclk_q <= '0;
      ccal_q   <= '0;
      fcal_q   <= '0;
    end else begin
      refclk_q <= cal_ref_period;
      ccal_q   <= {cal_crs_dly, cal_crs_ref};
      fcal_q   <= {cal_fin_dly, cal_fin_ref};
    end
  end

  always_comb begin
    case (cls)
      RC_GLOCK:  rd_word = {16'h0, bank_locked ? KEY_SHUT : KEY_OPEN};
      RC_REFCLK: rd_word = {16'h0, refclk_q};
      RC_CCAL:   rd_word = ccal_q;
      RC_FCAL:   rd_word = fcal_q;
      RC_PAD:    rd_word = pad_rword;
      default:   rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_req;
      if (rd_req) rdata_q <= rd_word;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;

endmodule

// File: rtl/iodly_regbank_chk.sv
module iodly_regbank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_req,
  input logic        wr_lock,
  input logic        wr_pad,
  input logic [31:0] wdata,
  input logic        addr_oob,
  input logic        wr_accept,
  input logic        wr_reject,
  input logic        bank_locked,
  input logic        wr_err,
  input logic        bus_rvalid,
  input logic [31:0] bus_rdata
);

  a_r2_bad_key_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lock && wdata[15:0] != 16'hAAAA && wdata[15:0] != 16'hAAAB)
      |=> $stable(bank_locked));

  a_r2_open_key: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lock && wdata[15:0] == 16'hAAAA) |=> !bank_locked);

  a_r2_shut_key: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lock && wdata[15:0] == 16'hAAAB) |=> bank_locked);

  a_r3_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> bus_rvalid);

  a_r3_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !bus_rvalid);

  a_r5_locked_rejects: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pad && bank_locked) |-> wr_reject);

  a_r5_bad_sig_rejects: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pad && wdata[17:12] != 6'h29) |-> !wr_accept);

  a_r6_reject_flags: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |=> wr_err);

  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |=> wr_err);

  a_r10_oob_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && addr_oob) |=> bus_rdata == 32'h0);

  a_r10_oob_no_error: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_oob && !wr_err) |=> (wr_err == $past(wr_pad && wr_reject)));

endmodule

bind iodly_regbank iodly_regbank_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_req     (rd_req),
  .wr_lock    (wr_lock),
  .wr_pad     (wr_pad),
  .wdata      (bus_wdata),
  .addr_oob   (addr_oob),
  .wr_accept  (wr_accept),
  .wr_reject  (wr_reject),
  .bank_locked(bank_locked),
  .wr_err     (wr_err),
  .bus_rvalid (bus_rvalid),
  .bus_rdata  (bus_rdata)
);

// File: tb/iodly_regbank_tb.sv
`timescale 1ns/1ps
module iodly_regbank_tb;

  localparam int AW    = 12;
  localparam int NPADS = 276;
  localparam int RPP   = 3;
  localparam int PW    = $clog2(NPADS + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_sel, bus_wr;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;
  logic          bus_rvalid;
  logic [15:0]   c_per, c_cref, c_cdly, c_fref, c_fdly;
  logic [PW-1:0] pad_sel;
  logic [4:0]    pad_coarse, pad_fine;
  logic          bank_locked, wr_err;

  always #4 clk = ~clk;

  iodly_regbank #(.ADDR_W(AW), .NUM_PADS(NPADS), .REGS_PER_PAD(RPP)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .cal_ref_period(c_per), .cal_crs_ref(c_cref),
    .cal_crs_dly(c_cdly), .cal_fin_ref(c_fref), .cal_fin_dly(c_fdly),
    .pad_sel(pad_sel), .pad_coarse(pad_coarse), .pad_fine(pad_fine),
    .bank_locked(bank_locked), .wr_err(wr_err)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  bit          m_locked;
  bit          m_err;
  logic [31:0] m_mem [int];

  function automatic logic [31:0] m_get(int w);
    return m_mem.exists(w) ? m_mem[w] : 32'h0;
  endfunction

  function automatic logic [31:0] mk(logic [5:0] sig, logic lk, logic [4:0] crs,
                                     logic [4:0] fin, logic [31:0] extra);
    return extra | (32'(sig) << 12) | (32'(lk) << 10) | (32'(crs) << 5) | 32'(fin);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // scoreboard monitor: pops one expected item per read response
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        check("R3 unexpected response", 32'h1, 32'h0);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    repeat (3) @(negedge clk);
    m_locked = 1'b1; m_err = 1'b0; m_mem.delete();
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_write(int addr, logic [31:0] d);
    int w = addr >> 2;
    if (w == 11) begin
      if (d[15:0] == 16'hAAAA) m_locked = 1'b0;
      else if (d[15:0] == 16'hAAAB) m_locked = 1'b1;
    end else if (w >= 12 && w < 12 + NPADS * RPP) begin
      logic [31:0] cur = m_get(w);
      if (!m_locked && !cur[10] && d[17:12] == 6'h29) m_mem[w] = d;
      else m_err = 1'b1;
    end
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(addr); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(string req, int addr);
    int w = addr >> 2;
    logic [31:0] e;
    if (w == 11) e = {16'h0, m_locked ? 16'hAAAB : 16'hAAAA};
    else if (w == 5) e = {16'h0, c_per};
    else if (w == 6) e = {c_cdly, c_cref};
    else if (w == 7) e = {c_fdly, c_fref};
    else if (w >= 12 && w < 12 + NPADS * RPP) e = m_get(w);
    else e = 32'h0;
    exp_q.push_back(e); tag_q.push_back(req);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = AW'(addr);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic check_view(string req, int p);
    logic [31:0] w;
    pad_sel = PW'(p);
    #1;
    w = (p < NPADS) ? m_get(12 + 3 * p) : 32'h0;
    check(req, {22'h0, pad_coarse, pad_fine}, {22'h0, w[9:5], w[4:0]});
  endtask

  task automatic check_flags(string req);
    check(req, {30'h0, bank_locked, wr_err}, {30'h0, m_locked, m_err});
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    bus_addr = '0; bus_wdata = '0; pad_sel = '0;
    c_per = 16'h1234; c_cref = 16'h0055; c_cdly = 16'h0aa0;
    c_fref = 16'h0033; c_fdly = 16'h0c0c;
    do_reset();

    // R1 reset state
    check("R1 flags", {30'h0, bank_locked, wr_err}, {30'h0, 1'b1, 1'b0});
    check("R1 rvalid", {31'h0, bus_rvalid}, 32'h0);
    bus_read("R1 lock reg", 32'h2C);
    bus_read("R1 pad word", 32'h30);
    check_view("R1 view", 0);

    // R4 calibration readback and write immunity
    bus_read("R4 refclk", 32'h14);
    bus_read("R4 coarse cal", 32'h18);
    bus_read("R4 fine cal", 32'h1C);
    bus_write(32'h18, 32'hFFFF_FFFF);
    bus_read("R4 write ignored", 32'h18);
    check_flags("R4 no error on cal write");
    c_cref = 16'h0101; c_fdly = 16'h7777;
    repeat (2) @(negedge clk);
    bus_read("R4 port follow coarse", 32'h18);
    bus_read("R4 port follow fine", 32'h1C);

    // R5/R6 write while locked
    pad_sel = '0;
    bus_write(32'h30, mk(6'h29, 1'b0, 5'h13, 5'h0A, 32'h0));
    check_flags("R5 locked write rejected");
    bus_read("R6 locked word unchanged", 32'h30);
    check_view("R6 view unchanged", 0);
    repeat (3) @(negedge clk);
    check_flags("R6 sticky");

    // R2 key handling
    do_reset();
    bus_write(32'h2C, 32'h0000_1234);
    check_flags("R2 bad key ignored");
    bus_read("R2 lock reg after bad key", 32'h2C);
    bus_write(32'h2C, 32'hFFFF_AAAA);
    check_flags("R2 open key");
    bus_read("R2 lock reg open", 32'h2C);

    // R5/R8/R9 accepted write on viewed pad, readback next cycle
    check_view("R9 view before", 0);
    bus_write(32'h30, mk(6'h29, 1'b0, 5'h13, 5'h0A, 32'h8000_0000));
    check_view("R9 view after write", 0);
    bus_read("R8 full word readback", 32'h30);
    check_flags("R5 accepted no error");

    // R6 bad signature
    bus_write(32'h30, mk(6'h28, 1'b0, 5'h01, 5'h01, 32'h0));
    check_flags("R6 bad signature sets error");
    bus_read("R6 word kept", 32'h30);
    check_view("R6 view kept", 0);

    // R10/R11 map edges
    do_reset();
    bus_write(32'h2C, 32'h0000_AAAA);
    bus_write(32'h30 + 12 * 5 + 4, mk(6'h29, 1'b0, 5'h02, 5'h03, 32'h0));
    bus_read("R11 pad5 second word", 32'h30 + 12 * 5 + 4);
    check_view("R11 pad5 view uses first word", 5);
    bus_write(32'hD14, mk(6'h29, 1'b0, 5'h1F, 5'h11, 32'h4));
    bus_write(32'hD1C, mk(6'h29, 1'b0, 5'h0F, 5'h0E, 32'h0));
    bus_read("R11 last word", 32'hD1C);
    check_view("R11 last pad view", 275);
    bus_write(32'hD20, mk(6'h29, 1'b0, 5'h1, 5'h1, 32'h0));
    bus_read("R10 beyond range", 32'hD20);
    bus_write(32'h04, 32'hDEAD_BEEF);
    bus_read("R10 unused offset", 32'h04);
    bus_read("R10 gap offset", 32'h24);
    check_flags("R10 no error");
    check_view("R9 pad_sel out of range", NPADS);

    // R7 per-register lock bit
    bus_write(32'h3C, mk(6'h29, 1'b1, 5'h0C, 5'h05, 32'h0));
    check_view("R7 locked word visible", 1);
    bus_write(32'h3C, mk(6'h29, 1'b0, 5'h01, 5'h02, 32'h0));
    check_flags("R7 frozen word rejects");
    bus_read("R7 frozen word kept", 32'h3C);
    check_view("R7 view kept", 1);

    // R2/R5 closing the bank blocks writes
    do_reset();
    bus_write(32'h2C, 32'h0000_AAAA);
    bus_write(32'h2C, 32'h0000_AAAB);
    check_flags("R2 shut key");
    bus_write(32'h48, mk(6'h29, 1'b0, 5'h04, 5'h04, 32'h0));
    check_flags("R5 closed bank rejects");
    bus_read("R5 closed bank word", 32'h48);

    repeat (4) @(negedge clk);
    check("R3 all reads answered", 32'(exp_q.size()), 32'h0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule